// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit device virtual address into a physical address by reading a two-level translation table out of memory. A requester hands it one virtual address at a time. The walker reads the first-level word and decodes it. It either finishes at once, with a 1 MB section or a fault, or it follows a pointer to a second-level table and reads one more word there. That second word resolves to a 64 KB large page, a 4 KB small page or a fault.

The memory side is a simple read port with one read in flight at most. There is a request handshake, then a data return some cycles later. The first-level table base comes in on a configuration input and is assumed to be 16 KB aligned.

The result is presented on a response channel. It carries the physical address, the mapping size, a fault flag with the table level that faulted, and the original virtual address. The response stays put until the consumer takes it.

Top module: `page_walker`

## Requirements
- R1: The first table read goes to address {cfg_l1_base[31:14], va[31:20], 2'b00}.
- R2: A first-level word whose bits [1:0] are 00 or 11 ends the walk with rsp_fault=1 and rsp_fault_lvl=0, and no second read is issued.
- R3: A first-level word with bits [1:0]=10 is a section: rsp_pa = {word[31:20], va[19:0]} and rsp_size=2.
- R4: A first-level word with bits [1:0]=01 points to a second-level table. The second read goes to {word[31:10], va[19:12], 2'b00}, so word bits [9:2] are ignored.
- R5: A second-level word with bits [1:0]=00 ends the walk with rsp_fault=1 and rsp_fault_lvl=1.
- R6: A second-level word with bits [1:0]=01 is a large page: rsp_pa = {word[31:16], va[15:0]} and rsp_size=1. Each of the 16 slots that a 64 KB page spans yields the same page base.
- R7: A second-level word with bit 1 set (10 or 11) is a small page: rsp_pa = {word[31:12], va[11:0]} and rsp_size=0.
- R8: While rsp_valid=1 and rsp_ready=0, the response and every response field hold unchanged.
- R9: req_ready is high only when no walk is in progress. A request presented while busy is ignored until the walker is idle. At most one memory read is outstanding.
- R10: Every response returns the walked virtual address on rsp_va. A fault response has rsp_pa=0 and rsp_size=0.
- R11: Bits [13:0] of cfg_l1_base have no effect on any read address or result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_l1_base | input | 32 | First-level table base address |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_va | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_pa | output | 32 | Translated physical address |
| rsp_size | output | 2 | 0 small page, 1 large page, 2 section |
| rsp_fault | output | 1 | Translation failed |
| rsp_fault_lvl | output | 1 | Level of the faulting word (0 first, 1 second) |
| rsp_va | output | 32 | Virtual address that was walked |
| mem_rd_valid | output | 1 | Table read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 32 | Byte address of the table word |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Table word |

## Verification
The hardest situations to reach from the ports are the back-pressure overlaps. A new request can be waiting while a walk is still in its second-level wait. The consumer can stall while the memory port is also throttling reads and returning data late. The stimulus replays the same address set in three conditions: with free-flowing handshakes, with periodic stalls on both the read port and the response channel, and with garbage in the low bits of the configured base. Requests stay asserted across busy periods, so the ignore-while-busy behaviour and the response hold are exercised on every walk.

// File: rtl/pw_pkg.sv
package pw_pkg;

  typedef enum logic [2:0] {
    K_FAULT,
    K_TABLE,
    K_SECT,
    K_LARGE,
    K_SMALL
  } pw_kind_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_L1_RD,
    S_L1_WT,
    S_L2_RD,
    S_L2_WT,
    S_DONE
  } pw_state_e;

  localparam logic [1:0] SZ_SMALL = 2'd0;
  localparam logic [1:0] SZ_LARGE = 2'd1;
  localparam logic [1:0] SZ_SECT  = 2'd2;

endpackage

// File: rtl/pw_entry_decode.sv
module pw_entry_decode
  import pw_pkg::*;
#(
  parameter int LEVEL = 1
) (
  input  logic [1:0] tag,
  output pw_kind_e   kind
);

  generate
    if (LEVEL == 1) begin : g_first
      always_comb begin
        case (tag)
          2'b01:   kind = K_TABLE;
          2'b10:   kind = K_SECT;
          default: kind = K_FAULT;
        endcase
      end
    end else begin : g_second
      always_comb begin
        if (tag[1])             kind = K_SMALL;
        else if (tag[0])        kind = K_LARGE;
        else                    kind = K_FAULT;
      end
    end
  endgenerate

endmodule

// File: rtl/pw_pa_compose.sv
module pw_pa_compose
  import pw_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int L1_IDX_W = 12,
  parameter int L2_IDX_W = 8,
  parameter int LARGE_SH = 16
) (
  input  pw_kind_e                             kind,
  input  logic [ADDR_W-L1_IDX_W-L2_IDX_W-1+L1_IDX_W:0] hi_bits,
  input  logic [ADDR_W-L1_IDX_W-1:0]           va_low,
  output logic [ADDR_W-1:0]                    pa,
  output logic [1:0]                           size
);

  localparam int SECT_SH  = ADDR_W - L1_IDX_W;
  localparam int SMALL_SH = SECT_SH - L2_IDX_W;
  localparam int HI_W     = ADDR_W - SMALL_SH;

  always_comb begin
    pa   = '0;
    size = SZ_SMALL;
    case (kind)
      K_SECT: begin
        pa   = {hi_bits[HI_W-1 -: L1_IDX_W], va_low[SECT_SH-1:0]};
        size = SZ_SECT;
      end
      K_LARGE: begin
        pa   = {hi_bits[HI_W-1 -: ADDR_W-LARGE_SH], va_low[LARGE_SH-1:0]};
        size = SZ_LARGE;
      end
      K_SMALL: begin
        pa   = {hi_bits, va_low[SMALL_SH-1:0]};
        size = SZ_SMALL;
      end
      default: begin
        pa   = '0;
        size = SZ_SMALL;
      end
    endcase
  end

endmodule

// File: rtl/page_walker.sv
module page_walker
  import pw_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int L1_IDX_W = 12,
  parameter int L2_IDX_W = 8,
  parameter int LARGE_SH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cfg_l1_base,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_va,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_pa,
  output logic [1:0]        rsp_size,
  output logic              rsp_fault,
  output logic              rsp_fault_lvl,
  output logic [ADDR_W-1:0] rsp_va,
  output logic              mem_rd_valid,
  input  logic              mem_rd_ready,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data
);

  localparam int SECT_SH  = ADDR_W - L1_IDX_W;
  localparam int SMALL_SH = SECT_SH - L2_IDX_W;
  localparam int L1_ALIGN = L1_IDX_W + 2;
  localparam int L2_ALIGN = L2_IDX_W + 2;

  pw_state_e         state;
  logic [ADDR_W-1:0] va_q;
  logic [ADDR_W-1:0] addr_q;
  pw_kind_e          kind_l1;
  pw_kind_e          kind_l2;
  pw_kind_e          kind_cur;
  logic [ADDR_W-1:0] comp_pa;
  logic [1:0]        comp_size;
  logic              unused_bits;

  assign unused_bits = ^{cfg_l1_base[L1_ALIGN-1:0], mem_rsp_data[L2_ALIGN-1:2]};

  pw_entry_decode #(.LEVEL(1)) u_dec_l1 (
    .tag  (mem_rsp_data[1:0]),
    .kind (kind_l1)
  );

  pw_entry_decode #(.LEVEL(2)) u_dec_l2 (
    .tag  (mem_rsp_data[1:0]),
    .kind (kind_l2)
  );

  assign kind_cur = (state == S_L1_WT) ? kind_l1 : kind_l2;

  pw_pa_compose #(
    .ADDR_W   (ADDR_W),
    .L1_IDX_W (L1_IDX_W),
    .L2_IDX_W (L2_IDX_W),
    .LARGE_SH (LARGE_SH)
  ) u_compose (
    .kind    (kind_cur),
    .hi_bits (mem_rsp_data[ADDR_W-1:SMALL_SH]),
    .va_low  (va_q[SECT_SH-1:0]),
    .pa      (comp_pa),
    .size    (comp_size)
  );

  assign req_ready    = (state == S_IDLE);
  assign rsp_valid    = (state == S_DONE);
  assign mem_rd_valid = (state == S_L1_RD) || (state == S_L2_RD);
  assign mem_rd_addr  = addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= S_IDLE;
      va_q          <= '0;
      addr_q        <= '0;
      rsp_pa        <= '0;
      rsp_size      <= '0;
      rsp_fault     <= 1'b0;
      rsp_fault_lvl <= 1'b0;
      rsp_va        <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            va_q   <= req_va;
            addr_q <= {cfg_l1_base[ADDR_W-1:L1_ALIGN],
                       req_va[ADDR_W-1 -: L1_IDX_W], 2'b00};
            state  <= S_L1_RD;
          end
        end
        S_L1_RD: if (mem_rd_ready) state <= S_L1_WT;
        S_L1_WT: begin
          if (mem_rsp_valid) begin
            if (kind_l1 == K_TABLE) begin
              addr_q <= {mem_rsp_data[ADDR_W-1:L2_ALIGN],
                         va_q[SECT_SH-1 -: L2_IDX_W], 2'b00};
              state  <= S_L2_RD;
            end else begin
              rsp_fault     <= (kind_l1 == K_FAULT);
              rsp_fault_lvl <= 1'b0;
              rsp_pa        <= comp_pa;
              rsp_size      <= comp_size;
              rsp_va        <= va_q;
              state         <= S_DONE;
            end
          end
        end
        S_L2_RD: if (mem_rd_ready) state <= S_L2_WT;
        S_L2_WT: begin
          if (mem_rsp_valid) begin
            rsp_fault     <= (kind_l2 == K_FAULT);
            rsp_fault_lvl <= 1'b1;
            rsp_pa        <= comp_pa;
            rsp_size      <= comp_size;
            rsp_va        <= va_q;
            state         <= S_DONE;
          end
        end
        S_DONE:  if (rsp_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R8: the response holds while it is stalled
  p_rsp_hold_r8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_pa) && $stable(rsp_size)
      && $stable(rsp_fault) && $stable(rsp_fault_lvl) && $stable(rsp_va));

  // R9: one read in flight, so a taken read is not followed by another at once
  p_one_read_r9: assert property (@(posedge clk) disable iff (rst)
    mem_rd_valid && mem_rd_ready |=> !mem_rd_valid);

  // R9: an idle walker has neither a response nor a read pending
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !rsp_valid && !mem_rd_valid);

  // R10: a fault carries a zero address and zero size
  p_fault_zero_r10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_fault |-> rsp_pa == '0 && rsp_size == 2'd0);

  // R1: the first read after acceptance is indexed by the top address bits
  p_l1_index_r1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(req_valid && req_ready) |->
      mem_rd_valid && mem_rd_addr[L1_ALIGN-1:2] == $past(req_va[ADDR_W-1 -: L1_IDX_W]));

endmodule

// File: tb/page_walker_bench.sv
module page_walker_bench;

  typedef struct {
    logic [31:0] va;
    logic [31:0] pa;
    logic        f;
    logic        lvl;
    logic [1:0]  sz;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] cfg_l1_base = 32'h0008_0000;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_pa;
  logic [1:0]  rsp_size;
  logic        rsp_fault;
  logic        rsp_fault_lvl;
  logic [31:0] rsp_va;
  logic        mem_rd_valid;
  logic        mem_rd_ready = 1'b0;
  logic [31:0] mem_rd_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  always #4 clk = ~clk;

  page_walker u_page_walker (
    .clk(clk), .rst(rst), .cfg_l1_base(cfg_l1_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_pa(rsp_pa),
    .rsp_size(rsp_size), .rsp_fault(rsp_fault), .rsp_fault_lvl(rsp_fault_lvl),
    .rsp_va(rsp_va), .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
    .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  logic [31:0] tbl [logic [31:0]];
  logic [31:0] issue_q [$];
  exp_t        exp_q [$];
  logic [31:0] rd_q [$];
  string       rd_tag_q [$];

  int  checks = 0;
  int  bad = 0;
  int  cyc = 0;
  bit  stall = 0;
  bit  busy = 0;
  bit  drop_next = 0;
  bit  pend = 0;
  int  pend_wait = 0;
  logic [31:0] pend_addr;
  bit  hold_prev = 0;
  logic [31:0] h_pa, h_va;
  logic [1:0]  h_sz;
  logic        h_f, h_lvl;

  function automatic logic [31:0] rdw(input logic [31:0] a);
    return tbl.exists(a) ? tbl[a] : 32'h0;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  // Behavioural walk of the table from the requirements
  task automatic model(input logic [31:0] va);
    exp_t e;
    logic [31:0] b, a1, a2, w1, w2;
    string pre;
    pre = (cfg_l1_base[13:0] != 0) ? "R11 " : "";
    b  = cfg_l1_base & 32'hFFFF_C000;
    a1 = b + {18'd0, va[31:20], 2'b00};
    w1 = rdw(a1);
    e.va = va; e.pa = 0; e.f = 0; e.lvl = 0; e.sz = 0;
    rd_q.push_back(a1); rd_tag_q.push_back({pre, "R1"});
    if (w1[1:0] == 2'b10) begin
      e.pa = {w1[31:20], va[19:0]}; e.sz = 2; e.tag = {pre, "R3"};
    end else if (w1[1:0] == 2'b01) begin
      a2 = (w1 & 32'hFFFF_FC00) + {22'd0, va[19:12], 2'b00};
      rd_q.push_back(a2); rd_tag_q.push_back({pre, "R4"});
      w2 = rdw(a2);
      e.lvl = 1;
      if (w2[1]) begin
        e.pa = {w2[31:12], va[11:0]}; e.sz = 0; e.tag = {pre, "R7"};
      end else if (w2[0]) begin
        e.pa = {w2[31:16], va[15:0]}; e.sz = 1; e.tag = {pre, "R6"};
      end else begin
        e.f = 1; e.tag = {pre, "R5"};
      end
    end else begin
      e.f = 1; e.tag = {pre, "R2"};
    end
    exp_q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      exp_t e;
      cyc++;
      if (drop_next) begin req_valid = 1'b0; drop_next = 0; end

      // R9: request acceptance follows the walk occupancy every cycle
      chk(req_ready == !busy, "R9", "req_ready", {31'd0, req_ready}, {31'd0, !busy});

      // R8: a stalled response must not change
      if (hold_prev) begin
        chk(rsp_valid && rsp_pa == h_pa && rsp_va == h_va && rsp_sz_ok(h_sz)
            && rsp_fault == h_f && rsp_fault_lvl == h_lvl,
            "R8", "held response", rsp_pa, h_pa);
      end

      // memory model
      mem_rsp_valid = 1'b0;
      if (pend) begin
        chk(!mem_rd_valid, "R9", "read while outstanding", {31'd0, mem_rd_valid}, 32'd0);
        if (pend_wait == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = rdw(pend_addr);
          pend = 0;
        end else pend_wait--;
      end
      mem_rd_ready = stall ? (cyc % 2 == 0) : 1'b1;
      if (!pend && mem_rd_valid && mem_rd_ready) begin
        if (rd_q.size() == 0) begin
          chk(0, "R2", "unexpected read", mem_rd_addr, 32'h0);
        end else begin
          chk(mem_rd_addr == rd_q[0], rd_tag_q[0], "read address", mem_rd_addr, rd_q[0]);
          void'(rd_q.pop_front()); void'(rd_tag_q.pop_front());
        end
        pend = 1; pend_wait = stall ? 2 : 0; pend_addr = mem_rd_addr;
      end

      // response side
      rsp_ready = stall ? (cyc % 3 != 0) : 1'b1;
      if (rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) begin
          chk(0, "R9", "unexpected response", rsp_va, 32'h0);
        end else begin
          e = exp_q.pop_front();
          chk(rsp_fault == e.f, e.tag, "fault", {31'd0, rsp_fault}, {31'd0, e.f});
          chk(rsp_pa == e.pa, e.tag, "pa", rsp_pa, e.pa);
          chk(rsp_size == e.sz, e.tag, "size", {30'd0, rsp_size}, {30'd0, e.sz});
          if (e.f) chk(rsp_fault_lvl == e.lvl, e.tag, "fault level",
                       {31'd0, rsp_fault_lvl}, {31'd0, e.lvl});
          chk(rsp_va == e.va, "R10", "va", rsp_va, e.va);
          chk(rd_q.size() == 0, e.tag, "reads left", rd_q.size(), 32'd0);
        end
        busy = 0;
      end
      hold_prev = rsp_valid && !rsp_ready;
      h_pa = rsp_pa; h_va = rsp_va; h_sz = rsp_size; h_f = rsp_fault; h_lvl = rsp_fault_lvl;

      // request side; held high while busy so the walker must ignore it (R9)
      if (!req_valid && !drop_next && issue_q.size() > 0) begin
        req_valid = 1'b1;
        req_va    = issue_q.pop_front();
      end
      if (req_valid && req_ready) begin
        model(req_va);
        busy = 1;
        drop_next = 1;
      end
    end
  end

  function automatic bit rsp_sz_ok(input logic [1:0] s);
    return rsp_size == s;
  endfunction

  task automatic load_set();
    issue_q.push_back(32'h1234_5678);
    issue_q.push_back(32'h124A_BCDE);
    issue_q.push_back(32'h1250_0000);
    issue_q.push_back(32'h2000_3ABC);
    issue_q.push_back(32'h2000_4DEF);
    issue_q.push_back(32'h2000_5000);
    issue_q.push_back(32'h2001_5678);
    issue_q.push_back(32'h2001_0000);
    issue_q.push_back(32'h2001_FFFF);
    issue_q.push_back(32'hFFF8_0001);
  endtask

  task automatic drain();
    while (issue_q.size() > 0 || busy || req_valid) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [31:0] b, t;
    b = 32'h0008_0000;
    t = 32'h0004_0400;
    tbl[b + 32'h123 * 4] = 32'h4560_0002;   // section
    tbl[b + 32'h124 * 4] = 32'h0000_0003;   // reserved tag: fault
    tbl[b + 32'h200 * 4] = 32'h0004_05E1;   // pointer with junk in [9:2]
    tbl[b + 32'hFFF * 4] = 32'h0010_0002;   // section at the top index
    tbl[t + 32'h03 * 4]  = 32'h7654_3002;   // small
    tbl[t + 32'h04 * 4]  = 32'h1111_2003;   // small, bit 0 also set
    for (int i = 16; i < 32; i++) tbl[t + i * 4] = 32'hABCD_0001; // large x16
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // reset state
    chk(req_ready && !rsp_valid && !mem_rd_valid, "R9", "reset outputs",
        {29'd0, req_ready, rsp_valid, mem_rd_valid}, 32'h4);
    load_set();
    drain();
    stall = 1;
    load_set();
    drain();
    stall = 0;
    cfg_l1_base = 32'h0008_2A5C;            // R11: low bits must not matter
    load_set();
    drain();
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not end actual=%0d expected=%0d", 50000, 0);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule